// File: doc/BRIEF.md
# ADC Sample Sequencer with Digital Loopback

This block is the digital engine that runs a list of analog samples for a converter. Software programs a small table of sample slots. Each slot holds an input select and four control bits: differential, temperature sensor, interrupt enable and end of list. A trigger pulse starts the walk at slot 0. Each slot drives one start request to the external converter. The returned result goes into an 8-entry result FIFO, and the walk stops after the slot marked as the end.

A loopback test mode lets software be checked without any analog stimulus. In this mode the converter is not started. Each slot instead completes one cycle after it is issued, and it pushes a synthetic 10-bit word. That word holds a running 4-bit sample count, a continuation flag and the slot's own configuration bits.

A trigger that arrives in the same cycle as the final slot's completion restarts the list at once, which gives back-to-back sampling at full rate. All control and status is reached through a single-cycle register port, and results are taken from a separate FIFO read port.

Top module: `smp_seq_top`

## Requirements
- R1: After reset, every slot control field reads 0b0010 (end-of-list set), every input select reads 0, loopback reads 0, FIFO status reads 0x1 (empty), and `irq` and `conv_start` are low.
- R2: Register map, with reads returned one cycle after `reg_rd`:
  - address 0x00 is loopback enable in bit 0, and its other bits read 0;
  - address 0x01 is interrupt status in bit 0, cleared by writing 1 to that bit;
  - address 0x02 is FIFO status: bit 0 empty, bit 1 full, bit 2 overflow, bit 3 underflow;
  - address 0x08+n is slot n input select, bits 2:0;
  - address 0x10+n is slot n control: bit 0 differential, bit 1 end-of-list, bit 2 interrupt enable, bit 3 temperature sensor. Only bits 3:0 are stored.
- R3: A trigger seen while idle starts at slot 0. Slots are processed in ascending order, and the list stops after the slot whose end bit is set, or after the last slot.
- R4: A trigger seen while a list is running is ignored. The only exception is the cycle in which the final slot completes.
- R5: Outside loopback, each slot raises `conv_start` for exactly one cycle, with `conv_sel`, `conv_diff` and `conv_ts` taken from that slot. A `conv_valid` is accepted from the next cycle onward. The FIFO word is `conv_data` in bits 9:0, with the upper bits 0.
- R6: In loopback, the FIFO word is laid out as follows: bits 9:6 sample count, bit 5 continuation, bit 4 differential, bit 3 temperature sensor, bits 2:0 input select. No `conv_start` is raised in this mode.
- R7: The sample count starts at 0 after reset. It advances by one for every completed sample, in either mode and whether or not the FIFO accepts the word, and it wraps at 16.
- R8: The continuation bit is 0 for the first sample after idle. It is 1 for every later slot of a list, and for slot 0 of a list restarted in the cycle the previous list finished.
- R9: Completing a slot with interrupt enable set drives `irq` high. It stays high until 1 is written to bit 0 of address 0x01.
- R10: The FIFO holds 8 words. `fifo_full` is set at 8 words. A push while full is dropped and sets the sticky overflow bit.
- R11: A FIFO read while empty leaves `fifo_rdata` unchanged and sets the sticky underflow bit. Writing 1 to status bits 2 or 3 clears the matching sticky bit.
- R12: FIFO words are returned in the order they were pushed, one cycle after `fifo_rd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 6 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, valid the cycle after `reg_rd` |
| trig | input | 1 | Start request for the slot list |
| conv_start | output | 1 | One-cycle converter start |
| conv_sel | output | 3 | Analog input select for the current slot |
| conv_diff | output | 1 | Differential select for the current slot |
| conv_ts | output | 1 | Temperature-sensor select for the current slot |
| conv_valid | input | 1 | Converter result strobe |
| conv_data | input | 10 | Converter result |
| fifo_rd | input | 1 | FIFO read strobe |
| fifo_rdata | output | 16 | FIFO read word |
| fifo_empty | output | 1 | FIFO holds no words |
| fifo_full | output | 1 | FIFO holds 8 words |
| irq | output | 1 | Interrupt, held until cleared |

## Verification
A corrupted slot index or a stale slot latch shows up in the very next FIFO word. That word carries the wrong select or flag bits in loopback, or the wrong `conv_sel` during the `conv_start` cycle. A sample counter that skipped or repeated would misplace bits 9:6 of every later loopback word, so one slip persists for the rest of the run. FIFO pointer or count faults appear at the read port as out-of-order words, or as a full or empty flag that disagrees with the number of pushes minus reads. An interrupt latch fault shows as `irq` dropping without a clear write, or never rising after an enabled slot.

// File: rtl/smp_seq_pkg.sv
package smp_seq_pkg;

  localparam int REG_AW   = 6;
  localparam int REG_DW   = 32;
  localparam int SEL_W    = 3;
  localparam int CTL_W    = 4;
  localparam int LB_CNT_W = 4;
  localparam int LB_W     = LB_CNT_W + 3 + SEL_W;

  // control bit positions inside a slot
  localparam int CTL_DIFF = 0;
  localparam int CTL_END  = 1;
  localparam int CTL_IE   = 2;
  localparam int CTL_TS   = 3;
  localparam logic [CTL_W-1:0] CTL_RESET = 4'b0010;

  // register addresses
  localparam logic [REG_AW-1:0] A_LOOP     = 6'h00;
  localparam logic [REG_AW-1:0] A_IRQ      = 6'h01;
  localparam logic [REG_AW-1:0] A_FSTAT    = 6'h02;
  localparam logic [REG_AW-1:0] A_SEL_BASE = 6'h08;
  localparam logic [REG_AW-1:0] A_CTL_BASE = 6'h10;

  // FIFO status bit positions
  localparam int ST_EMPTY = 0;
  localparam int ST_FULL  = 1;
  localparam int ST_OVF   = 2;
  localparam int ST_UDF   = 3;

  typedef enum logic [1:0] {SQ_IDLE, SQ_ISSUE, SQ_WAIT} seq_state_e;

  typedef struct packed {
    logic [SEL_W-1:0] sel;
    logic [CTL_W-1:0] ctl;
  } slot_cfg_t;

endpackage

// File: rtl/smp_seq_cfg.sv
module smp_seq_cfg
  import smp_seq_pkg::*;
#(
  parameter int NUM_SLOTS = 4
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      reg_wr,
  input  logic                      reg_rd,
  input  logic [REG_AW-1:0]         reg_addr,
  input  logic [REG_DW-1:0]         reg_wdata,
  output logic [REG_DW-1:0]         reg_rdata,
  output slot_cfg_t [NUM_SLOTS-1:0] slots,
  output logic                      lb_en,
  input  logic                      irq_state,
  input  logic                      fifo_empty,
  input  logic                      fifo_full,
  input  logic                      fifo_ovf,
  input  logic                      fifo_udf,
  output logic                      irq_clr,
  output logic                      ovf_clr,
  output logic                      udf_clr
);

  logic [REG_DW-1:0] rd_mux;
  logic              wdata_unused;

  assign wdata_unused = ^reg_wdata[REG_DW-1:CTL_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      lb_en <= 1'b0;
      for (int i = 0; i < NUM_SLOTS; i++) begin
        slots[i].sel <= '0;
        slots[i].ctl <= CTL_RESET;
      end
    end else if (reg_wr) begin
      if (reg_addr == A_LOOP) lb_en <= reg_wdata[0];
      for (int i = 0; i < NUM_SLOTS; i++) begin
        if (reg_addr == A_SEL_BASE + REG_AW'(i)) slots[i].sel <= reg_wdata[SEL_W-1:0];
        if (reg_addr == A_CTL_BASE + REG_AW'(i)) slots[i].ctl <= reg_wdata[CTL_W-1:0];
      end
    end
  end

  always_comb begin
    rd_mux = '0;
    case (reg_addr)
      A_LOOP:  rd_mux[0] = lb_en;
      A_IRQ:   rd_mux[0] = irq_state;
      A_FSTAT: begin
        rd_mux[ST_EMPTY] = fifo_empty;
        rd_mux[ST_FULL]  = fifo_full;
        rd_mux[ST_OVF]   = fifo_ovf;
        rd_mux[ST_UDF]   = fifo_udf;
      end
      default: ;
    endcase
    for (int i = 0; i < NUM_SLOTS; i++) begin
      if (reg_addr == A_SEL_BASE + REG_AW'(i)) rd_mux[SEL_W-1:0] = slots[i].sel;
      if (reg_addr == A_CTL_BASE + REG_AW'(i)) rd_mux[CTL_W-1:0] = slots[i].ctl;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_mux;
  end

  assign irq_clr = reg_wr && (reg_addr == A_IRQ)   && reg_wdata[0];
  assign ovf_clr = reg_wr && (reg_addr == A_FSTAT) && reg_wdata[ST_OVF];
  assign udf_clr = reg_wr && (reg_addr == A_FSTAT) && reg_wdata[ST_UDF];

endmodule

// File: rtl/smp_seq_ctrl.sv
module smp_seq_ctrl
  import smp_seq_pkg::*;
#(
  parameter int NUM_SLOTS = 4,
  parameter int RES_W     = 10
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      trig,
  input  slot_cfg_t [NUM_SLOTS-1:0] slots,
  input  logic                      lb_en,
  input  logic                      conv_valid,
  input  logic [RES_W-1:0]          conv_data,
  output logic                      conv_start,
  output logic [SEL_W-1:0]          conv_sel,
  output logic                      conv_diff,
  output logic                      conv_ts,
  output logic                      push,
  output logic [RES_W-1:0]          push_data,
  output logic                      irq_set,
  output logic                      busy
);

  localparam int IDX_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_SLOTS - 1);

  seq_state_e          state;
  logic [IDX_W-1:0]    idx;
  slot_cfg_t           cur;
  logic                cur_lb;
  logic                cur_cont;
  logic [LB_CNT_W-1:0] cnt;
  logic                done;
  logic                last;
  logic                load_go;
  logic                load_cont;
  logic [IDX_W-1:0]    load_idx;
  logic [RES_W-1:0]    lb_word;

  assign done = (state == SQ_WAIT) && (cur_lb || conv_valid);
  assign last = cur.ctl[CTL_END] || (idx == LAST_IDX);
  assign busy = (state != SQ_IDLE);

  assign lb_word = RES_W'({cnt, cur_cont, cur.ctl[CTL_DIFF], cur.ctl[CTL_TS], cur.sel});

  // which slot is loaded next, and whether it continues without a gap
  always_comb begin
    load_go   = 1'b0;
    load_cont = 1'b0;
    load_idx  = '0;
    if (state == SQ_IDLE && trig) begin
      load_go = 1'b1;
    end else if (done && !last) begin
      load_go   = 1'b1;
      load_cont = 1'b1;
      load_idx  = idx + 1'b1;
    end else if (done && trig) begin
      load_go   = 1'b1;
      load_cont = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= SQ_IDLE;
      idx        <= '0;
      cur        <= '0;
      cur_lb     <= 1'b0;
      cur_cont   <= 1'b0;
      cnt        <= '0;
      conv_start <= 1'b0;
      push       <= 1'b0;
      push_data  <= '0;
      irq_set    <= 1'b0;
    end else begin
      push    <= 1'b0;
      irq_set <= 1'b0;
      if (state == SQ_ISSUE) begin
        conv_start <= 1'b0;
        state      <= SQ_WAIT;
      end
      if (done) begin
        push      <= 1'b1;
        push_data <= cur_lb ? lb_word : conv_data;
        cnt       <= cnt + 1'b1;
        irq_set   <= cur.ctl[CTL_IE];
        state     <= SQ_IDLE;
      end
      if (load_go) begin
        idx        <= load_idx;
        cur        <= slots[load_idx];
        cur_lb     <= lb_en;
        cur_cont   <= load_cont;
        conv_start <= !lb_en;
        state      <= SQ_ISSUE;
      end
    end
  end

  assign conv_sel  = cur.sel;
  assign conv_diff = cur.ctl[CTL_DIFF];
  assign conv_ts   = cur.ctl[CTL_TS];

endmodule

// File: rtl/smp_seq_fifo.sv
module smp_seq_fifo #(
  parameter int DEPTH = 8,
  parameter int W     = 10
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  output logic [W-1:0] rdata,
  output logic         empty,
  output logic         full,
  output logic         ovf,
  output logic         udf,
  input  logic         ovf_clr,
  input  logic         udf_clr
);

  // DEPTH is a power of two so the pointers wrap naturally
  localparam int PW = $clog2(DEPTH);

  logic [W-1:0] mem [DEPTH];
  logic [PW-1:0] wp;
  logic [PW-1:0] rp;
  logic [PW:0]   cnt;
  logic          do_wr;
  logic          do_rd;

  assign empty = (cnt == '0);
  assign full  = (cnt == (PW+1)'(DEPTH));
  assign do_wr = push && !full;
  assign do_rd = pop && !empty;

  always_ff @(posedge clk) begin
    if (do_wr) mem[wp] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (do_rd) rdata <= mem[rp];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
      ovf <= 1'b0;
      udf <= 1'b0;
    end else begin
      if (do_wr) wp <= wp + 1'b1;
      if (do_rd) rp <= rp + 1'b1;
      cnt <= cnt + (PW+1)'(do_wr) - (PW+1)'(do_rd);
      if (push && full)       ovf <= 1'b1;
      else if (ovf_clr)       ovf <= 1'b0;
      if (pop && empty)       udf <= 1'b1;
      else if (udf_clr)       udf <= 1'b0;
    end
  end

endmodule

// File: rtl/smp_seq_top.sv
module smp_seq_top
  import smp_seq_pkg::*;
#(
  parameter int NUM_SLOTS  = 4,
  parameter int FIFO_DEPTH = 8,
  parameter int RES_W      = 10,
  parameter int RD_W       = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [REG_DW-1:0] reg_wdata,
  output logic [REG_DW-1:0] reg_rdata,
  input  logic              trig,
  output logic              conv_start,
  output logic [SEL_W-1:0]  conv_sel,
  output logic              conv_diff,
  output logic              conv_ts,
  input  logic              conv_valid,
  input  logic [RES_W-1:0]  conv_data,
  input  logic              fifo_rd,
  output logic [RD_W-1:0]   fifo_rdata,
  output logic              fifo_empty,
  output logic              fifo_full,
  output logic              irq
);

  slot_cfg_t [NUM_SLOTS-1:0] slots;
  logic             lb_en;
  logic             irq_clr;
  logic             ovf_clr;
  logic             udf_clr;
  logic             fifo_ovf;
  logic             fifo_udf;
  logic             push;
  logic [RES_W-1:0] push_data;
  logic             irq_set;
  logic             seq_busy;
  logic [RES_W-1:0] fifo_q;

  smp_seq_cfg #(.NUM_SLOTS(NUM_SLOTS)) u_cfg (
    .clk        (clk),
    .rst        (rst),
    .reg_wr     (reg_wr),
    .reg_rd     (reg_rd),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .slots      (slots),
    .lb_en      (lb_en),
    .irq_state  (irq),
    .fifo_empty (fifo_empty),
    .fifo_full  (fifo_full),
    .fifo_ovf   (fifo_ovf),
    .fifo_udf   (fifo_udf),
    .irq_clr    (irq_clr),
    .ovf_clr    (ovf_clr),
    .udf_clr    (udf_clr)
  );

  smp_seq_ctrl #(.NUM_SLOTS(NUM_SLOTS), .RES_W(RES_W)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .trig       (trig),
    .slots      (slots),
    .lb_en      (lb_en),
    .conv_valid (conv_valid),
    .conv_data  (conv_data),
    .conv_start (conv_start),
    .conv_sel   (conv_sel),
    .conv_diff  (conv_diff),
    .conv_ts    (conv_ts),
    .push       (push),
    .push_data  (push_data),
    .irq_set    (irq_set),
    .busy       (seq_busy)
  );

  smp_seq_fifo #(.DEPTH(FIFO_DEPTH), .W(RES_W)) u_fifo (
    .clk       (clk),
    .rst       (rst),
    .push      (push),
    .push_data (push_data),
    .pop       (fifo_rd),
    .rdata     (fifo_q),
    .empty     (fifo_empty),
    .full      (fifo_full),
    .ovf       (fifo_ovf),
    .udf       (fifo_udf),
    .ovf_clr   (ovf_clr),
    .udf_clr   (udf_clr)
  );

  // set wins over a clear in the same cycle
  always_ff @(posedge clk) begin
    if (rst)          irq <= 1'b0;
    else if (irq_set) irq <= 1'b1;
    else if (irq_clr) irq <= 1'b0;
  end

  assign fifo_rdata = RD_W'(fifo_q);

endmodule

// File: rtl/smp_seq_chk.sv
module smp_seq_chk #(
  parameter int RD_W = 16
) (
  input logic            clk,
  input logic            rst,
  input logic            irq_clr,
  input logic            conv_start,
  input logic            busy,
  input logic            fifo_rd,
  input logic            fifo_empty,
  input logic            fifo_full,
  input logic [RD_W-1:0] fifo_rdata,
  input logic            irq
);

  // R1
  reset_state_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (fifo_empty && !irq && !conv_start));

  // R5
  start_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    conv_start |=> !conv_start);

  // R3
  start_busy_chk: assert property (@(posedge clk) disable iff (rst)
    conv_start |-> busy);

  // R9
  irq_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (irq && !irq_clr) |=> irq);

  // R10
  full_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (fifo_full && !fifo_rd) |=> fifo_full);

  // R11
  empty_read_chk: assert property (@(posedge clk) disable iff (rst)
    (fifo_empty && fifo_rd) |=> $stable(fifo_rdata));

  // R10
  flags_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(fifo_full && fifo_empty));

endmodule

bind smp_seq_top smp_seq_chk #(.RD_W(RD_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .irq_clr    (irq_clr),
  .conv_start (conv_start),
  .busy       (seq_busy),
  .fifo_rd    (fifo_rd),
  .fifo_empty (fifo_empty),
  .fifo_full  (fifo_full),
  .fifo_rdata (fifo_rdata),
  .irq        (irq)
);

// File: tb/test_smp_seq_top.sv
`timescale 1ns/1ps
module test_smp_seq_top;

  localparam real CLK_HALF = 2.5;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [5:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        trig = 1'b0;
  logic        conv_start;
  logic [2:0]  conv_sel;
  logic        conv_diff;
  logic        conv_ts;
  logic        conv_valid = 1'b0;
  logic [9:0]  conv_data = '0;
  logic        fifo_rd = 1'b0;
  logic [15:0] fifo_rdata;
  logic        fifo_empty;
  logic        fifo_full;
  logic        irq;

  int checks = 0;
  int errors = 0;
  int exp_cnt = 0;
  int n_starts = 0;
  bit finished = 1'b0;
  logic [15:0] q_data[$];
  string       q_tag[$];

  always #(CLK_HALF) clk = ~clk;

  smp_seq_top i_smp_seq_top (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .trig(trig), .conv_start(conv_start),
    .conv_sel(conv_sel), .conv_diff(conv_diff), .conv_ts(conv_ts), .conv_valid(conv_valid),
    .conv_data(conv_data), .fifo_rd(fifo_rd), .fifo_rdata(fifo_rdata),
    .fifo_empty(fifo_empty), .fifo_full(fifo_full), .irq(irq)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] lbw(int c, int cont, int d, int t, int s);
    return 16'(((c % 16) << 6) + (cont << 5) + (d << 4) + (t << 3) + (s % 8));
  endfunction

  // driver side of the scoreboard
  task automatic expect_word(logic [15:0] w, string tag);
    q_data.push_back(w);
    q_tag.push_back(tag);
  endtask

  // monitor: compares each read word against the queue head
  always @(negedge clk) begin
    if (conv_start) n_starts++;
    if (fifo_rd && q_data.size() > 0) begin
      logic [15:0] e;
      string t;
      e = q_data.pop_front();
      t = q_tag.pop_front();
      check(t, 32'(fifo_rdata), 32'(e));
    end
  end

  task automatic reg_write(logic [5:0] a, logic [31:0] d);
    @(negedge clk); #1;
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); #1;
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(logic [5:0] a, output logic [31:0] d);
    @(negedge clk); #1;
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
    #1 reg_rd = 1'b0;
  endtask

  task automatic read_check(logic [5:0] a, logic [31:0] exp, string tag);
    logic [31:0] v;
    reg_read(a, v);
    check(tag, v, exp);
  endtask

  task automatic pulse_trig();
    @(negedge clk); #1 trig = 1'b1;
    @(negedge clk); #1 trig = 1'b0;
  endtask

  task automatic pop();
    @(negedge clk); #1 fifo_rd = 1'b1;
    @(negedge clk); #1 fifo_rd = 1'b0;
  endtask

  task automatic conv_respond(logic [9:0] d);
    @(negedge clk); #1 conv_valid = 1'b1; conv_data = d;
    @(negedge clk); #1 conv_valid = 1'b0;
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_HALF * 2 * 100000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog R3 actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    int starts0;
    repeat (4) @(negedge clk);
    #1 rst = 1'b0;

    // R1 reset values
    read_check(6'h10, 32'h2, "R1 slot0 control");
    read_check(6'h0B, 32'h0, "R1 slot3 select");
    read_check(6'h00, 32'h0, "R1 loopback");
    read_check(6'h02, 32'h1, "R1 fifo status");
    check("R1 irq", 32'(irq), 32'h0);

    // R2 writable bit masks
    reg_write(6'h00, 32'hFFFF_FFFF);
    read_check(6'h00, 32'h1, "R2 loopback mask");
    reg_write(6'h11, 32'hFFFF_FFFF);
    read_check(6'h11, 32'hF, "R2 control mask");

    // R6 R7 single loopback slot, temp sensor, select 5
    reg_write(6'h10, 32'hA);
    reg_write(6'h08, 32'h5);
    pulse_trig();
    repeat (8) @(negedge clk);
    expect_word(lbw(exp_cnt, 0, 0, 1, 5), "R6 R7 single loopback word");
    exp_cnt++;
    pop();
    check("R9 no irq without enable", 32'(irq), 32'h0);

    // R3 R8 R9 three-slot list
    reg_write(6'h10, 32'h1); reg_write(6'h08, 32'h1);
    reg_write(6'h11, 32'h4); reg_write(6'h09, 32'h2);
    reg_write(6'h12, 32'h2); reg_write(6'h0A, 32'h7);
    pulse_trig();
    repeat (12) @(negedge clk);
    expect_word(lbw(exp_cnt,     0, 1, 0, 1), "R3 R8 slot0 word");
    expect_word(lbw(exp_cnt + 1, 1, 0, 0, 2), "R3 R8 slot1 word");
    expect_word(lbw(exp_cnt + 2, 1, 0, 0, 7), "R3 R8 slot2 word");
    exp_cnt += 3;
    check("R10 fifo not empty", 32'(fifo_empty), 32'h0);
    repeat (3) pop();
    check("R9 irq held", 32'(irq), 32'h1);
    reg_write(6'h01, 32'h1);
    check("R9 irq cleared", 32'(irq), 32'h0);

    // R5 normal conversion
    reg_write(6'h00, 32'h0);
    reg_write(6'h10, 32'hB); reg_write(6'h08, 32'h3);
    pulse_trig();
    while (!conv_start) @(negedge clk);
    check("R5 conv_sel", 32'(conv_sel), 32'h3);
    check("R5 conv flags", 32'({conv_diff, conv_ts}), 32'h3);
    conv_respond(10'h3A5);
    repeat (6) @(negedge clk);
    expect_word(16'h03A5, "R5 converter word");
    exp_cnt++;
    pop();

    // R4 trigger during a running list
    starts0 = n_starts;
    pulse_trig();
    pulse_trig();
    conv_respond(10'h1C3);
    repeat (10) @(negedge clk);
    check("R4 single start", 32'(n_starts - starts0), 32'h1);
    expect_word(16'h01C3, "R4 one word");
    exp_cnt++;
    pop();
    read_check(6'h02, 32'h1, "R4 fifo empty after one read");

    // R8 back-to-back restart at full rate
    reg_write(6'h00, 32'h1);
    reg_write(6'h10, 32'h2); reg_write(6'h08, 32'h0);
    @(negedge clk); #1 trig = 1'b1;
    repeat (4) @(negedge clk);
    #1 trig = 1'b0;
    repeat (6) @(negedge clk);
    expect_word(lbw(exp_cnt,     0, 0, 0, 0), "R8 first of pair");
    expect_word(lbw(exp_cnt + 1, 1, 0, 0, 0), "R8 continued sample");
    exp_cnt += 2;
    pop(); pop();

    // R10 R11 R12 R7 overflow, order, underflow
    for (int i = 0; i < 4; i++) begin
      reg_write(6'(8 + i), 32'(i));
      reg_write(6'(16 + i), (i == 3) ? 32'h2 : 32'h0);
    end
    for (int p = 0; p < 2; p++) begin
      pulse_trig();
      repeat (14) @(negedge clk);
      for (int s = 0; s < 4; s++) begin
        expect_word(lbw(exp_cnt, (s != 0) ? 1 : 0, 0, 0, s), "R12 R7 fifo order word");
        exp_cnt++;
      end
    end
    read_check(6'h02, 32'h2, "R10 full status");
    pulse_trig();
    repeat (14) @(negedge clk);
    exp_cnt += 4;
    read_check(6'h02, 32'h6, "R10 overflow sticky");
    for (int k = 0; k < 8; k++) pop();
    expect_word(lbw(exp_cnt - 5, 1, 0, 0, 3), "R11 empty read keeps word");
    pop();
    read_check(6'h02, 32'hD, "R11 underflow status");
    reg_write(6'h02, 32'hC);
    read_check(6'h02, 32'h1, "R11 sticky cleared");

    // R7 counter continues after dropped samples
    reg_write(6'h10, 32'h2);
    pulse_trig();
    repeat (8) @(negedge clk);
    expect_word(lbw(exp_cnt, 0, 0, 0, 0), "R7 wrapped count");
    exp_cnt++;
    pop();
    repeat (2) @(negedge clk);
    check("R12 queue drained", 32'(q_data.size()), 32'h0);

    finished = 1'b1;
    finish_run();
  end

endmodule